// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between a 24-bit, byte-addressed 68000-style CPU bus and a cartridge that holds up to 4 MB of ROM plus a small battery-backed SRAM. It keeps one 8-bit control value. The CPU sets that value by writing to a decoded spot in the lowest 64 KB of address space. Bit 7 of the value steers the translation. Every CPU address is turned, combinationally, into a ROM byte address. When a window is routed to SRAM, the address becomes an SRAM select and an SRAM offset instead.

A parameter picks one of two layouts:

- **Low-swap layout.** Bit 7 replaces the lowest 256 KB window with the 256 KB ROM bank at 0x380000. The same bit also hands the topmost 256 KB window (0x3C0000–0x3FFFFF) to SRAM.
- **Mid-swap layout.** Bit 7 makes the region 0x200000–0x3BFFFF show the ROM from offset 0, in place of its own bank.

A load port lets system software put back a saved control value. The full 8-bit value is visible on an output, so it can be saved.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU write whose address has bits [23:16] equal to 0 and bits [11:8] equal to 4'hE loads the control value at the next rising clock edge. Translation uses the old value until that edge and the new value from then on.
- R2: Any other write leaves the control value unchanged. This includes writes that land in ROM-mapped space or in the SRAM window.
- R3: For a word write (bus_size=1), the control value takes bus_wdata[7:0]. For a byte write (bus_size=0), it takes bus_wdata[7:0] when address bit 0 is 1 and bus_wdata[15:8] when address bit 0 is 0.
- R4: Reset (rst_n low, asynchronous) clears the control value to 8'h00. With that value every address maps by identity and SRAM is not selected.
- R5: In the low-swap layout with bit 7 set:
  - CPU 0x000000–0x03FFFF maps to rom_addr = 0x380000 + address[17:0].
  - CPU 0x3C0000–0x3FFFFF raises sram_sel, and rom_addr there stays the identity.
  - sram_we is high exactly when sram_sel and bus_wr are both high.
- R6: In the low-swap layout with bit 7 clear, both the lowest and the topmost 256 KB windows map by identity, and sram_sel stays low.
- R7: In the mid-swap layout:
  - With bit 7 set, CPU 0x200000–0x3BFFFF maps to rom_addr = address − 0x200000.
  - With bit 7 clear, that region maps by identity.
  - sram_sel is never raised in this layout.
- R8: Every address outside the remapped windows maps to rom_addr = address[21:0]. Examples are 0x040000–0x1FFFFF, and 0x3C0000 in the mid-swap layout. sram_off always equals address[15:0].
- R9: All 8 bits of the control value are kept and shown on ctl_value. Only bit 7 affects translation.
- R10: When ld_en is high at a rising edge, the control value takes ld_val. This wins over a decoded CPU write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | CPU byte address |
| bus_wr | input | 1 | CPU write strobe for the current bus cycle |
| bus_size | input | 1 | 1 = word write, 0 = byte write |
| bus_wdata | input | 16 | CPU write data; the even byte is on [15:8] |
| ld_en | input | 1 | Load the control value from ld_val |
| ld_val | input | 8 | Saved control value to restore |
| rom_addr | output | 22 | Translated ROM byte address |
| sram_sel | output | 1 | Current address is routed to SRAM |
| sram_we | output | 1 | SRAM write enable |
| sram_off | output | 16 | SRAM byte offset |
| ctl_value | output | 8 | Current control value |

## Verification
The bench builds two instances that share one stimulus stream:

- u0 uses the default low-swap layout.
- u1 uses the mid-swap layout.

Each register write therefore exercises both generate variants at once, and every probed address is scored against both translations. Two kinds of case become reachable this way. The first is the window edges: 0x03FFFF/0x040000, 0x1FFFFF/0x200000 and 0x3BFFFF/0x3C0000. The second is where one layout remaps and the other passes through, including SRAM offset aliasing across the whole top window.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
    typedef enum logic {
        MAP_LOW_SWAP = 1'b0,
        MAP_MID_SWAP = 1'b1
    } map_mode_e;

    localparam int CTL_W    = 8;
    localparam int SWAP_BIT = 7;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_state_t;
endpackage

// File: rtl/cbm_ctl_decode.sv
`timescale 1ns/1ps
module cbm_ctl_decode #(
    parameter int         ADDR_W  = 24,
    parameter int         DEC_AW  = 16,
    parameter logic [3:0] SEL_NIB = 4'hE
) (
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_size,
    input  logic [15:0]               bus_wdata,
    output logic                      ctl_hit,
    output logic [cbm_pkg::CTL_W-1:0] ctl_byte
);
    always_comb begin
        ctl_hit = bus_wr
               && (bus_addr[ADDR_W-1:DEC_AW] == '0)
               && (bus_addr[11:8] == SEL_NIB);
        // word writes and odd-byte writes use the low lane
        if (bus_size || bus_addr[0]) begin
            ctl_byte = bus_wdata[7:0];
        end else begin
            ctl_byte = bus_wdata[15:8];
        end
    end
endmodule

// File: rtl/cbm_ctl_reg.sv
`timescale 1ns/1ps
module cbm_ctl_reg
    import cbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CTL_W-1:0] wr_byte,
    input  logic             ld_en,
    input  logic [CTL_W-1:0] ld_val,
    output logic [CTL_W-1:0] ctl_q
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.ctl = ld_val;
        end else if (wr_hit) begin
            st_d.ctl = wr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;
endmodule

// File: rtl/cbm_xlate.sv
`timescale 1ns/1ps
module cbm_xlate
    import cbm_pkg::*;
#(
    parameter int        ADDR_W  = 24,
    parameter int        ROM_AW  = 22,
    parameter int        SRAM_AW = 16,
    parameter int        WIN_AW  = 18,
    parameter map_mode_e MODE    = MAP_LOW_SWAP
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               swap,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               sram_sel,
    output logic [SRAM_AW-1:0] sram_off
);
    localparam int                PAGE_W   = ADDR_W - WIN_AW;
    localparam logic [PAGE_W-1:0] TOP_PAGE = PAGE_W'((1 << (ROM_AW - WIN_AW)) - 1);

    logic [PAGE_W-1:0] page;
    assign page     = addr[ADDR_W-1:WIN_AW];
    assign sram_off = addr[SRAM_AW-1:0];

    generate
        if (MODE == MAP_LOW_SWAP) begin : g_low
            localparam logic [PAGE_W-1:0] ALT_PAGE = TOP_PAGE - PAGE_W'(1);
            always_comb begin
                rom_addr = addr[ROM_AW-1:0];
                sram_sel = 1'b0;
                if (swap && (page == '0)) begin
                    rom_addr = {ALT_PAGE[ROM_AW-WIN_AW-1:0], addr[WIN_AW-1:0]};
                end
                if (swap && (page == TOP_PAGE)) begin
                    sram_sel = 1'b1;
                end
            end
        end else begin : g_mid
            localparam logic [PAGE_W-1:0] MID_FIRST = PAGE_W'(1 << (ROM_AW - 1 - WIN_AW));
            always_comb begin
                rom_addr = addr[ROM_AW-1:0];
                sram_sel = 1'b0;
                if (swap && (page >= MID_FIRST) && (page < TOP_PAGE)) begin
                    rom_addr = {1'b0, addr[ROM_AW-2:0]};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int        ADDR_W  = 24,
    parameter int        ROM_AW  = 22,
    parameter int        SRAM_AW = 16,
    parameter int        WIN_AW  = 18,
    parameter int        DEC_AW  = 16,
    parameter map_mode_e MODE    = MAP_LOW_SWAP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_size,
    input  logic [15:0]        bus_wdata,
    input  logic               ld_en,
    input  logic [CTL_W-1:0]   ld_val,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               sram_sel,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_off,
    output logic [CTL_W-1:0]   ctl_value
);
    logic             hit;
    logic [CTL_W-1:0] wbyte;

    cbm_ctl_decode #(.ADDR_W(ADDR_W), .DEC_AW(DEC_AW), .SEL_NIB(4'hE)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .ctl_hit  (hit),
        .ctl_byte (wbyte)
    );

    cbm_ctl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit),
        .wr_byte(wbyte),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .ctl_q  (ctl_value)
    );

    cbm_xlate #(
        .ADDR_W (ADDR_W),
        .ROM_AW (ROM_AW),
        .SRAM_AW(SRAM_AW),
        .WIN_AW (WIN_AW),
        .MODE   (MODE)
    ) u_xl (
        .addr    (bus_addr),
        .swap    (ctl_value[SWAP_BIT]),
        .rom_addr(rom_addr),
        .sram_sel(sram_sel),
        .sram_off(sram_off)
    );

    assign sram_we = bus_wr & sram_sel;
endmodule

// File: rtl/cbm_checker.sv
`timescale 1ns/1ps
module cbm_checker
    import cbm_pkg::*;
#(
    parameter int        ADDR_W = 24,
    parameter int        ROM_AW = 22,
    parameter int        WIN_AW = 18,
    parameter map_mode_e MODE   = MAP_LOW_SWAP
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_size,
    input logic [15:0]       bus_wdata,
    input logic              ld_en,
    input logic [CTL_W-1:0]  ld_val,
    input logic              sram_sel,
    input logic              sram_we,
    input logic [CTL_W-1:0]  ctl_value
);
    localparam int                PW  = ADDR_W - WIN_AW;
    localparam logic [PW-1:0]     TOP = PW'((1 << (ROM_AW - WIN_AW)) - 1);

    logic             dec_hit;
    logic [CTL_W-1:0] lane;
    always_comb begin
        dec_hit = bus_wr && (bus_addr[ADDR_W-1:16] == '0) && (bus_addr[11:8] == 4'hE);
        lane    = (bus_size || bus_addr[0]) ? bus_wdata[7:0] : bus_wdata[15:8];
    end

    p_hit_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && !ld_en) |=> (ctl_value == $past(lane)));

    p_miss_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_hit && !ld_en) |=> $stable(ctl_value));

    p_reset_clear_r4: assert property (@(posedge clk)
        !rst_n |=> (ctl_value == '0));

    p_sram_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel |-> (ctl_value[SWAP_BIT] && (bus_addr[ADDR_W-1:WIN_AW] == TOP)));

    p_sram_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (sram_sel && bus_wr));

    p_no_sram_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel |-> (MODE == MAP_LOW_SWAP));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (ctl_value == $past(ld_val)));
endmodule

bind cart_bank_mapper cbm_checker #(
    .ADDR_W(ADDR_W),
    .ROM_AW(ROM_AW),
    .WIN_AW(WIN_AW),
    .MODE  (MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .sram_sel (sram_sel),
    .sram_we  (sram_we),
    .ctl_value(ctl_value)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_size = 1'b1;
    logic [15:0] bus_wdata = '0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_val = '0;

    logic [21:0] rom_a, rom_b;
    logic        ssel_a, ssel_b, we_a, we_b;
    logic [15:0] off_a, off_b;
    logic [7:0]  ctl_a, ctl_b;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cart_bank_mapper #(.MODE(cbm_pkg::MAP_LOW_SWAP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .ld_en(ld_en), .ld_val(ld_val),
        .rom_addr(rom_a), .sram_sel(ssel_a), .sram_we(we_a), .sram_off(off_a),
        .ctl_value(ctl_a)
    );

    cart_bank_mapper #(.MODE(cbm_pkg::MAP_MID_SWAP)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .ld_en(ld_en), .ld_val(ld_val),
        .rom_addr(rom_b), .sram_sel(ssel_b), .sram_we(we_b), .sram_off(off_b),
        .ctl_value(ctl_b)
    );

    typedef struct {
        logic [21:0] ra;
        logic        sa;
        logic        wa;
        logic [21:0] rb;
        logic [15:0] off;
        logic [7:0]  ctl;
        string       tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                cmp(it.tag, "u0 rom_addr", 32'(rom_a), 32'(it.ra));
                cmp(it.tag, "u0 sram_sel", 32'(ssel_a), 32'(it.sa));
                cmp(it.tag, "u0 sram_we", 32'(we_a), 32'(it.wa));
                cmp(it.tag, "u0 sram_off", 32'(off_a), 32'(it.off));
                cmp(it.tag, "u0 ctl_value", 32'(ctl_a), 32'(it.ctl));
                cmp(it.tag, "u1 rom_addr", 32'(rom_b), 32'(it.rb));
                cmp(it.tag, "u1 sram_sel (R7)", 32'(ssel_b), 32'(0));
                cmp(it.tag, "u1 sram_we (R7)", 32'(we_b), 32'(0));
                cmp(it.tag, "u1 sram_off", 32'(off_b), 32'(it.off));
                cmp(it.tag, "u1 ctl_value", 32'(ctl_b), 32'(it.ctl));
            end
        end
    end

    // driver: applies one bus cycle and pushes what both instances must show
    task automatic probe(input logic [23:0] a, input logic wr, input logic ld, input logic [7:0] ldv,
                         input logic [21:0] ra, input logic sa, input logic [21:0] rb,
                         input logic [7:0] c, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        bus_wr   = wr;
        ld_en    = ld;
        ld_val   = ldv;
        #5;
        it.ra = ra; it.sa = sa; it.wa = wr & sa; it.rb = rb;
        it.off = a[15:0]; it.ctl = c; it.tag = tag;
        q.push_back(it);
        ->sample_ev;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bus_wr = 1'b0;
        ld_en  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe(24'h001234, 0, 0, 8'h00, 22'h001234, 0, 22'h001234, 8'h00, "R4 reset identity");
        probe(24'h3C0010, 0, 0, 8'h00, 22'h3C0010, 0, 22'h3C0010, 8'h00, "R4/R6 top window ROM");
        bus_size = 1'b1; bus_wdata = 16'h0080;
        probe(24'h000E00, 1, 0, 8'h00, 22'h000E00, 0, 22'h000E00, 8'h00, "R1 old map before edge");
        probe(24'h000100, 0, 0, 8'h00, 22'h380100, 0, 22'h000100, 8'h80, "R1/R3/R5 low swap");
        probe(24'h3C1234, 0, 0, 8'h00, 22'h3C1234, 1, 22'h3C1234, 8'h80, "R5 SRAM read / R8");
        probe(24'h3C5678, 1, 0, 8'h00, 22'h3C5678, 1, 22'h3C5678, 8'h80, "R5 SRAM write");
        probe(24'h3FFFFF, 0, 0, 8'h00, 22'h3FFFFF, 1, 22'h3FFFFF, 8'h80, "R5 SRAM top / R2");
        probe(24'h040000, 0, 0, 8'h00, 22'h040000, 0, 22'h040000, 8'h80, "R8 past low window");
        probe(24'h200000, 0, 0, 8'h00, 22'h200000, 0, 22'h000000, 8'h80, "R7 mid start");
        probe(24'h3BFFFF, 0, 0, 8'h00, 22'h3BFFFF, 0, 22'h1BFFFF, 8'h80, "R7 mid end");
        probe(24'h1FFFFF, 0, 0, 8'h00, 22'h1FFFFF, 0, 22'h1FFFFF, 8'h80, "R8 below mid");
        bus_wdata = 16'h0000;
        probe(24'h000D00, 1, 0, 8'h00, 22'h380D00, 0, 22'h000D00, 8'h80, "R2 wrong nibble");
        probe(24'h010E00, 1, 0, 8'h00, 22'h390E00, 0, 22'h010E00, 8'h80, "R2 above range");
        probe(24'h100000, 1, 0, 8'h00, 22'h100000, 0, 22'h100000, 8'h80, "R2 ROM write");
        bus_size = 1'b0; bus_wdata = 16'h5A00;
        probe(24'h000E00, 1, 0, 8'h00, 22'h380E00, 0, 22'h000E00, 8'h80, "R2 ROM write held");
        probe(24'h000000, 0, 0, 8'h00, 22'h000000, 0, 22'h000000, 8'h5A, "R3 even byte / R6");
        bus_wdata = 16'h00A5;
        probe(24'h000E01, 1, 0, 8'h00, 22'h000E01, 0, 22'h000E01, 8'h5A, "R3 odd byte pre");
        probe(24'h3C0000, 0, 0, 8'h00, 22'h3C0000, 1, 22'h3C0000, 8'hA5, "R3 odd byte / R9");
        bus_size = 1'b1; bus_wdata = 16'h017F;
        probe(24'h00FE02, 1, 0, 8'h00, 22'h38FE02, 0, 22'h00FE02, 8'hA5, "R1 decode high offset");
        probe(24'h3C0002, 0, 0, 8'h00, 22'h3C0002, 0, 22'h3C0002, 8'h7F, "R9 low bits no swap");
        probe(24'h000000, 0, 1, 8'h81, 22'h000000, 0, 22'h000000, 8'h7F, "R10 load pre");
        probe(24'h000000, 0, 0, 8'h00, 22'h380000, 0, 22'h000000, 8'h81, "R10 load applied");
        bus_wdata = 16'h0080;
        probe(24'h000E00, 1, 1, 8'h03, 22'h380E00, 0, 22'h000E00, 8'h81, "R10 load vs write pre");
        probe(24'h3C0000, 0, 0, 8'h00, 22'h3C0000, 0, 22'h3C0000, 8'h03, "R10 load wins");
        probe(24'h200000, 0, 1, 8'h80, 22'h200000, 0, 22'h200000, 8'h03, "R7 mid clear identity");
        probe(24'h2ABCDE, 0, 0, 8'h00, 22'h2ABCDE, 0, 22'h0ABCDE, 8'h80, "R7 mid swapped");
        do_reset();
        probe(24'h000000, 0, 0, 8'h00, 22'h000000, 0, 22'h000000, 8'h00, "R4 reset mid-run");
        probe(24'h3C0004, 0, 0, 8'h00, 22'h3C0004, 0, 22'h3C0004, 8'h00, "R4 SRAM off after reset");
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule